// File: doc/BRIEF.md
# Transmit Word FIFO Loader with Parity Insertion

This block sits between a host bus and a serial line transmitter. The host writes each 32-bit transmit word as two 16-bit halves. It pulses one active-low strobe for the lower half and then a second active-low strobe for the upper half. The block joins each pair into one word and queues it in a 32-entry first-in, first-out store. Three flags report the fill level: full, below half, and empty ("transmitter ready").

A downstream serializer asks for the next word with a one-cycle pop request. One cycle later the block presents the oldest word with a one-cycle valid pulse. Word bits are numbered 1 to 32, and bit n sits at vector index n-1.

When parity mode is enabled, bit 32 of the outgoing word is replaced by a parity bit computed over bits 1 to 31. The sense input selects odd or even parity. When parity mode is disabled, all 32 stored bits leave unchanged. Both mode inputs are read at the moment of the pop, so a mode change applies to every word still waiting in the queue.

Top module: `txw_loader`

## Requirements
- R1: A falling edge of `ld_lo_n` captures `host_data` as word bits 16..1 (`[15:0]`). A later falling edge of `ld_hi_n` captures `host_data` as bits 32..17 (`[31:16]`) and enqueues the joined word at that same clock edge.
- R2: A falling edge of `ld_hi_n` with no first half pending since the last enqueue is ignored, and the queue is unchanged.
- R3: The queue holds 32 words. `full` is 1 exactly when it holds 32. Completed loads while full are dropped, and the stored contents are unchanged.
- R4: `below_half` is 1 exactly while the queue holds fewer than 16 words.
- R5: `tx_ready` is 1 exactly while the queue is empty.
- R6: Words leave in the order in which they were enqueued.
- R7: With `par_en`=1, output bit 32 (`word_out[31]`) is a parity bit over bits 31..1. With `par_even`=0 the 32-bit word has an odd count of ones, and with `par_even`=1 an even count.
- R8: With `par_en`=0, `word_out` equals the 32 stored bits unchanged.
- R9: `par_en` and `par_even` are applied as sampled in the pop cycle, not as they were when the word was loaded.
- R10: A pop request on a non-empty queue gives `word_valid`=1 for one cycle, in the cycle after the request. A pop request on an empty queue gives no `word_valid`.
- R11: After reset the queue is empty: `tx_ready`=1, `below_half`=1, `full`=0, `word_valid`=0, `word_out`=0.
- R12: Loads are edge-triggered: a strobe held low for several cycles counts as a single load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_data | input | 16 | Half-word from the host |
| ld_lo_n | input | 1 | Active-low strobe for the lower half |
| ld_hi_n | input | 1 | Active-low strobe for the upper half; completes a word |
| par_en | input | 1 | 1: bit 32 becomes parity; 0: raw 32-bit data |
| par_even | input | 1 | Parity sense: 0 odd, 1 even |
| pop_req | input | 1 | Request the oldest word |
| word_out | output | 32 | Popped word, valid when `word_valid` is 1 |
| word_valid | output | 1 | One-cycle pulse marking a popped word |
| full | output | 1 | Queue holds 32 words |
| below_half | output | 1 | Queue holds fewer than 16 words |
| tx_ready | output | 1 | Queue is empty |

## Verification
Random half-word values are loaded as pairs and popped under all four parity mode combinations. Mismatched halves, swapped halves or a wrong parity sense therefore show up as word errors. Modes are switched between loading and popping, which tells pop-time parity apart from load-time parity. Directed cases cover these situations:
- An upper-half strobe with no lower half before it, which separates a lone strobe from a real load.
- Strobes held low for several cycles, which separates edge detection from level detection.
- A fill to 32 followed by extra loads and then a full drain, which exposes overflow, wrap-around and flag-threshold errors.

// File: rtl/txw_pkg.sv
package txw_pkg;
   localparam int unsigned STROBES = 2;
   localparam int unsigned LO_IDX  = 0;
   localparam int unsigned HI_IDX  = 1;

   typedef struct packed {
      logic enable;
      logic even;
   } par_mode_t;
endpackage

// File: rtl/txw_edge.sv
module txw_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_n,
   output logic fall
);
   logic prev_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_n <= 1'b1;
      else        prev_n <= strobe_n;
   end

   assign fall = prev_n & ~strobe_n;
endmodule

// File: rtl/txw_assembler.sv
module txw_assembler #(
   parameter int unsigned HALF_W = 16,
   localparam int unsigned WORD_W = 2 * HALF_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [HALF_W-1:0]            host_data,
   input  logic [txw_pkg::STROBES-1:0]  strobe_n,
   output logic [txw_pkg::STROBES-1:0]  strobe_ev,
   output logic                         half_pending,
   output logic                         push,
   output logic [WORD_W-1:0]            push_word
);
   logic [HALF_W-1:0] lo_half;

   initial begin
      if (HALF_W < 1) $error("txw_assembler: HALF_W must be positive");
   end

   for (genvar s = 0; s < txw_pkg::STROBES; s++) begin : g_edge
      txw_edge u_edge (
         .clk      (clk),
         .rst_n    (rst_n),
         .strobe_n (strobe_n[s]),
         .fall     (strobe_ev[s])
      );
   end

   assign push      = strobe_ev[txw_pkg::HI_IDX] & half_pending;
   assign push_word = {host_data, lo_half};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_pending <= 1'b0;
         lo_half      <= '0;
      end else begin
         if (strobe_ev[txw_pkg::LO_IDX]) begin
            half_pending <= 1'b1;
            lo_half      <= host_data;
         end else if (push) begin
            half_pending <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/txw_store.sv
module txw_store #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned DEPTH  = 32,
   localparam int unsigned AW     = $clog2(DEPTH),
   localparam int unsigned CW     = $clog2(DEPTH + 1),
   localparam int unsigned HALF_MARK = DEPTH / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [WORD_W-1:0] push_word,
   input  logic              pop,
   output logic              pop_fire,
   output logic [WORD_W-1:0] head_word,
   output logic [CW-1:0]     fill_cnt,
   output logic              full,
   output logic              below_half,
   output logic              empty
);
   logic [WORD_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr;
   logic              wr_ok;

   initial begin
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0)
         $error("txw_store: DEPTH must be a power of two of at least 4");
   end

   assign full       = (fill_cnt == CW'(DEPTH));
   assign empty      = (fill_cnt == '0);
   assign below_half = (fill_cnt < CW'(HALF_MARK));
   assign wr_ok      = push & ~full;
   assign pop_fire   = pop & ~empty;
   assign head_word  = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         fill_cnt <= '0;
      end else begin
         if (wr_ok)    wr_ptr <= wr_ptr + 1'b1;
         if (pop_fire) rd_ptr <= rd_ptr + 1'b1;
         case ({wr_ok, pop_fire})
            2'b10:   fill_cnt <= fill_cnt + 1'b1;
            2'b01:   fill_cnt <= fill_cnt - 1'b1;
            default: fill_cnt <= fill_cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_ptr] <= push_word;
   end

   // R3: a completed load while full leaves the level untouched
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> $stable(fill_cnt));

   // R5 and R4: the flags are mutually consistent
   a_r5_ready_not_full: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> (!full && below_half));
   a_r4_full_not_below: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !below_half);
endmodule

// File: rtl/txw_out_stage.sv
module txw_out_stage #(
   parameter int unsigned WORD_W = 32,
   parameter bit          PARITY_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [WORD_W-1:0] raw_word,
   input  txw_pkg::par_mode_t mode,
   output logic [WORD_W-1:0] word_out,
   output logic              word_valid
);
   logic [WORD_W-1:0] shaped;

   initial begin
      if (WORD_W < 2) $error("txw_out_stage: WORD_W must be at least 2");
   end

   if (PARITY_SUPPORT) begin : g_parity
      logic body_xor;
      assign body_xor = ^raw_word[WORD_W-2:0];
      assign shaped = mode.enable
                    ? {(mode.even ? body_xor : ~body_xor), raw_word[WORD_W-2:0]}
                    : raw_word;

      // R7: the emitted word carries the requested parity sense
      a_r7_parity_sense: assert property (@(posedge clk) disable iff (!rst_n)
         (word_valid && $past(mode.enable)) |-> ((^word_out) == ~$past(mode.even)));
   end else begin : g_raw
      logic unused_mode;
      assign unused_mode = ^mode;
      assign shaped = raw_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_out   <= '0;
         word_valid <= 1'b0;
      end else begin
         word_valid <= fire;
         if (fire) word_out <= shaped;
      end
   end
endmodule

// File: rtl/txw_loader.sv
module txw_loader #(
   parameter int unsigned HALF_W = 16,
   parameter int unsigned DEPTH  = 32,
   parameter bit          PARITY_SUPPORT = 1'b1,
   localparam int unsigned WORD_W = 2 * HALF_W,
   localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HALF_W-1:0] host_data,
   input  logic              ld_lo_n,
   input  logic              ld_hi_n,
   input  logic              par_en,
   input  logic              par_even,
   input  logic              pop_req,
   output logic [WORD_W-1:0] word_out,
   output logic              word_valid,
   output logic              full,
   output logic              below_half,
   output logic              tx_ready
);
   logic [txw_pkg::STROBES-1:0] strobe_ev;
   logic                        half_pending;
   logic                        push, pop_fire;
   logic [WORD_W-1:0]           push_word, head_word;
   logic [CW-1:0]               fill_cnt;
   txw_pkg::par_mode_t          mode;

   assign mode = '{enable: par_en, even: par_even};

   txw_assembler #(.HALF_W(HALF_W)) u_asm (
      .clk          (clk),
      .rst_n        (rst_n),
      .host_data    (host_data),
      .strobe_n     ({ld_hi_n, ld_lo_n}),
      .strobe_ev    (strobe_ev),
      .half_pending (half_pending),
      .push         (push),
      .push_word    (push_word)
   );

   txw_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (push),
      .push_word  (push_word),
      .pop        (pop_req),
      .pop_fire   (pop_fire),
      .head_word  (head_word),
      .fill_cnt   (fill_cnt),
      .full       (full),
      .below_half (below_half),
      .empty      (tx_ready)
   );

   txw_out_stage #(.WORD_W(WORD_W), .PARITY_SUPPORT(PARITY_SUPPORT)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire       (pop_fire),
      .raw_word   (head_word),
      .mode       (mode),
      .word_out   (word_out),
      .word_valid (word_valid)
   );

   // R2: an upper-half strobe with nothing pending does not change the level
   a_r2_orphan_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_ev[txw_pkg::HI_IDX] && !half_pending && !pop_req) |=> $stable(fill_cnt));

   // R10: a pop on an empty queue yields no valid word
   a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && tx_ready) |=> !word_valid);
endmodule

// File: tb/txw_loader_bench.sv
`timescale 1ns/1ps
module txw_loader_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] host_data = '0;
   logic        ld_lo_n = 1'b1, ld_hi_n = 1'b1;
   logic        par_en = 1'b1, par_even = 1'b0;
   logic        pop_req = 1'b0;
   logic [31:0] word_out;
   logic        word_valid, full, below_half, tx_ready;

   int checks = 0, failures = 0;
   bit done = 1'b0;
   logic [31:0] model[$];

   always #2.5 clk = ~clk;

   txw_loader u_txw_loader (
      .clk(clk), .rst_n(rst_n), .host_data(host_data),
      .ld_lo_n(ld_lo_n), .ld_hi_n(ld_hi_n),
      .par_en(par_en), .par_even(par_even), .pop_req(pop_req),
      .word_out(word_out), .word_valid(word_valid),
      .full(full), .below_half(below_half), .tx_ready(tx_ready)
   );

   function automatic logic [31:0] expect_word(logic [31:0] raw, logic en, logic even);
      int ones = 0;
      if (!en) return raw;
      for (int i = 0; i < 31; i++) ones += raw[i];
      // odd sense: total ones odd; even sense: total ones even
      if (even) return {1'(ones % 2), raw[30:0]};
      return {1'(((ones % 2) == 0) ? 1 : 0), raw[30:0]};
   endfunction

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_flags(string req);
      int n = model.size();
      chk(full == (n == 32), {req, "/R3 full"}, 32'(full), 32'(n == 32));
      chk(below_half == (n < 16), {req, "/R4 below_half"}, 32'(below_half), 32'(n < 16));
      chk(tx_ready == (n == 0), {req, "/R5 tx_ready"}, 32'(tx_ready), 32'(n == 0));
   endtask

   task automatic strobe(bit hi, logic [15:0] d, int hold);
      @(negedge clk);
      host_data = d;
      if (hi) ld_hi_n = 1'b0; else ld_lo_n = 1'b0;
      repeat (hold) @(negedge clk);
      ld_hi_n = 1'b1; ld_lo_n = 1'b1;
   endtask

   task automatic load_word(logic [31:0] w, int hold);
      strobe(1'b0, w[15:0], hold);
      strobe(1'b1, w[31:16], hold);
      if (model.size() < 32) model.push_back(w);
   endtask

   task automatic pop_check(string req);
      logic [31:0] exp;
      bit          had = model.size() != 0;
      logic        en = par_en, ev = par_even;
      @(negedge clk);
      pop_req = 1'b1;
      @(negedge clk);
      pop_req = 1'b0;
      if (!had) begin
         chk(!word_valid, {req, "/R10 empty pop valid"}, 32'(word_valid), 32'd0);
      end else begin
         exp = expect_word(model.pop_front(), en, ev);
         chk(word_valid, {req, "/R10 valid"}, 32'(word_valid), 32'd1);
         chk(word_out == exp, {req, "/R6 word"}, word_out, exp);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] w;
      int unsigned seed;
      seed = $urandom(32'h5A17);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(tx_ready && below_half && !full, "R11 flags", {29'd0, tx_ready, below_half, full}, 32'd6);
      chk(!word_valid && word_out == 0, "R11 output", word_out, 32'd0);

      // R10: pop on empty
      pop_check("R10");

      // R1: half placement, raw mode (R8)
      par_en = 1'b0;
      load_word(32'hBEEF_1234, 1);
      check_flags("R1");
      pop_check("R1/R8");

      // R2: orphan upper strobe
      strobe(1'b1, 16'hDEAD, 1);
      check_flags("R2");
      chk(tx_ready, "R2 orphan ignored", 32'(tx_ready), 32'd1);

      // R12: held strobes count once
      load_word(32'h0F0F_A5A5, 4);
      check_flags("R12");
      pop_check("R12");
      check_flags("R12 drained");

      // R9 and R7: mode changes after loading
      par_en = 1'b1; par_even = 1'b0;
      load_word(32'h0000_0001, 1);
      load_word(32'h8000_0003, 1);
      load_word(32'hFFFF_FFFF, 1);
      par_even = 1'b1;
      pop_check("R9/R7 even");
      par_even = 1'b0;
      pop_check("R9/R7 odd");
      par_en = 1'b0;
      pop_check("R9/R8 raw");

      // R3: fill to 32, overload, drain in order
      for (int i = 0; i < 32; i++) begin
         load_word({16'(i * 3 + 7), 16'(i)} ^ 32'h3C3C_0000, 1);
         if (i == 14 || i == 15) check_flags("R4 edge");
      end
      check_flags("R3 full");
      for (int i = 0; i < 3; i++) load_word(32'hEEEE_EEEE, 1);
      check_flags("R3 overload");
      for (int i = 0; i < 32; i++) begin
         pop_check("R3/R6 drain");
         if (i == 16 || i == 17) check_flags("R4 drain edge");
      end
      check_flags("R5 empty");

      // random mix
      for (int it = 0; it < 800; it++) begin
         int unsigned r = $urandom % 10;
         if (r < 4) begin
            w = $urandom;
            load_word(w, 1 + ($urandom % 2));
         end else if (r == 4) begin
            strobe(1'b1, 16'($urandom), 1);
         end else if (r < 8) begin
            pop_check("R7/R8 random");
         end else begin
            par_en = 1'($urandom); par_even = 1'($urandom);
         end
         check_flags("random");
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule